// File: doc/BRIEF.md
# SPI FIFO and Interrupt Controller

This block sits between a 32-bit register bus and a serial shift engine. It holds two eight-word queues: one that software fills and the engine drains, and one that the engine fills and software drains. Software sets the fill levels at which the block raises a direct-memory request or a completion flag, and it can empty either queue. It reads a small status word and sets interrupt enables. A shared status/clear word reports the sticky event flags, and writing ones to that word clears them.

The bus side is one write strobe and one read strobe, with a byte offset. Reads return data in the same cycle. A read of the data offset removes the returned word at the next clock edge. The engine side takes the head word of the transmit queue with a one-cycle take pulse and delivers received words with a one-cycle put pulse.

Top module: `spi_fifo_irq`

## Requirements
- R1: After reset both queues are empty. All sticky flags and enables are zero, `irq` is low, the receive threshold reads 1 and the transmit threshold reads 7.
- R2: A write to offset 0x10 appends to the transmit queue, and the engine receives the words in write order on `eng_tx_word`. A read of offset 0x10 returns the oldest received word and removes it. Engine words are returned in arrival order.
- R3: A write to 0x10 while the transmit queue holds 8 words is ignored. A read of 0x10 while the receive queue is empty returns 0 and changes nothing.
- R4: Writing offset 0x0C with bit 12 set empties the transmit queue. Writing it with bit 4 set empties the receive queue.
- R5: Offset 0x00 reads `eng_busy` in bit 7 and "receive queue not empty" in bit 0. All other bits read 0.
- R6: A word delivered by the engine while the receive queue is full is dropped, and sticky flag bit 0 of offset 0x08 is set.
- R7: Bit 9 of offset 0x08 is high exactly while the receive threshold is nonzero and the receive fill level is at least that threshold. While that holds, sticky bit 3 is set and remains set after the level falls.
- R8: Sticky bit 4 of offset 0x08 is set when the engine takes the last word and leaves the transmit queue empty.
- R9: Writing a 1 to bit 4, 3 or 0 of offset 0x08 clears that flag. If the flag's setting condition holds in the same cycle, the set takes priority.
- R10: `irq` is high exactly while some flag among bits 4, 3 and 0 is set with the same bit set in the enable word at offset 0x04.
- R11: `rx_dma_req` is high while enable bit 1 is set and the R7 condition holds. `tx_dma_req` is high while enable bit 2 is set and the transmit fill level is at most the transmit threshold.
- R12: Offset 0x0C reads the transmit threshold in bits 11:8 and the receive threshold in bits 3:0. The flush bits 12 and 4 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | 6 | Bus byte offset |
| wdata | input | 32 | Bus write data |
| rdata | output | 32 | Bus read data, same cycle |
| eng_tx_take | input | 1 | Engine takes the transmit head word |
| eng_tx_valid | output | 1 | Transmit queue not empty |
| eng_tx_word | output | 32 | Transmit head word |
| eng_rx_put | input | 1 | Engine delivers a received word |
| eng_rx_word | input | 32 | Received word |
| eng_busy | input | 1 | Engine busy, reported in status |
| irq | output | 1 | Level interrupt |
| tx_dma_req | output | 1 | Transmit direct-memory request |
| rx_dma_req | output | 1 | Receive direct-memory request |

## Verification
Register writes and queue updates become visible one clock edge after the strobe. Sticky flags that follow a fill-level condition appear one edge later than that, because the level itself is registered first. `irq` and the request outputs follow their registered sources with no further delay. The bench drives every stimulus on the falling edge and waits a fixed number of cycles for each result: one for queue contents and enables, two for level-driven flags. It then samples on a falling edge, and it reads data combinationally before the edge that removes the word.

// File: rtl/spi_fifo_irq.sv
module spi_fifo_irq #(
  parameter int DEPTH = 8,
  parameter int DW    = 32,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          eng_tx_take,
  output logic          eng_tx_valid,
  output logic [DW-1:0] eng_tx_word,
  input  logic          eng_rx_put,
  input  logic [DW-1:0] eng_rx_word,
  input  logic          eng_busy,
  output logic          irq,
  output logic          tx_dma_req,
  output logic          rx_dma_req
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] A_STAT = AW'(0);
  localparam logic [AW-1:0] A_IEN  = AW'(4);
  localparam logic [AW-1:0] A_IST  = AW'(8);
  localparam logic [AW-1:0] A_FCTL = AW'(12);
  localparam logic [AW-1:0] A_DATA = AW'(16);

  logic [DW-1:0] tx_mem [DEPTH];
  logic [DW-1:0] rx_mem [DEPTH];
  logic [PW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [3:0]    tx_th, rx_th;
  logic [4:0]    ie;
  logic          st_tc, st_rc, st_ov;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  logic fc_wr, ist_wr, tx_flush, rx_flush;
  logic tx_pop, tx_push, rx_pop, rx_push;
  logic ov_ev, tc_ev, rx_hit, tx_room;

  assign fc_wr    = wr_en && (addr == A_FCTL);
  assign ist_wr   = wr_en && (addr == A_IST);
  assign tx_flush = fc_wr && wdata[12];
  assign rx_flush = fc_wr && wdata[4];
  assign tx_pop   = eng_tx_take && (tx_cnt != '0);
  assign tx_push  = wr_en && (addr == A_DATA) && ((tx_cnt != CW'(DEPTH)) || tx_pop);
  assign rx_pop   = rd_en && (addr == A_DATA) && (rx_cnt != '0);
  assign rx_push  = eng_rx_put && ((rx_cnt != CW'(DEPTH)) || rx_pop);
  assign ov_ev    = eng_rx_put && !rx_push && !rx_flush;
  assign tc_ev    = tx_pop && (tx_cnt == CW'(1)) && !tx_push && !tx_flush;
  assign rx_hit   = (rx_th != 4'd0) && (int'(rx_cnt) >= int'(rx_th));
  assign tx_room  = int'(tx_cnt) <= int'(tx_th);

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= wdata;
    if (rx_push) rx_mem[rx_wp] <= eng_rx_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else if (tx_flush) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= nxt(tx_wp);
      if (tx_pop)  tx_rp <= nxt(tx_rp);
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else if (rx_flush) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_push) rx_wp <= nxt(rx_wp);
      if (rx_pop)  rx_rp <= nxt(rx_rp);
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie    <= '0;
      tx_th <= 4'(DEPTH - 1);
      rx_th <= 4'd1;
      st_tc <= 1'b0;
      st_rc <= 1'b0;
      st_ov <= 1'b0;
    end else begin
      if (wr_en && (addr == A_IEN)) ie <= wdata[4:0];
      if (fc_wr) begin
        tx_th <= wdata[11:8];
        rx_th <= wdata[3:0];
      end
      st_tc <= tc_ev  | (st_tc & ~(ist_wr & wdata[4]));
      st_rc <= rx_hit | (st_rc & ~(ist_wr & wdata[3]));
      st_ov <= ov_ev  | (st_ov & ~(ist_wr & wdata[0]));
    end
  end

  assign eng_tx_valid = tx_cnt != '0;
  assign eng_tx_word  = eng_tx_valid ? tx_mem[tx_rp] : '0;
  assign irq          = (st_tc & ie[4]) | (st_rc & ie[3]) | (st_ov & ie[0]);
  assign tx_dma_req   = ie[2] & tx_room;
  assign rx_dma_req   = ie[1] & rx_hit;

  always_comb begin
    case (addr)
      A_STAT:  rdata = DW'({eng_busy, 6'b0, rx_cnt != '0});
      A_IEN:   rdata = DW'(ie);
      A_IST:   rdata = DW'({rx_hit, 4'b0, st_tc, st_rc, 2'b0, st_ov});
      A_FCTL:  rdata = DW'({tx_th, 4'b0, rx_th});
      A_DATA:  rdata = (rx_cnt != '0) ? rx_mem[rx_rp] : '0;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_fifo_irq_sva.sv
module spi_fifo_irq_sva #(
  parameter int DEPTH = 8,
  parameter int DW    = 32,
  parameter int AW    = 6
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       wr_en,
  input logic                       rd_en,
  input logic [AW-1:0]              addr,
  input logic                       wd0,
  input logic                       wd4,
  input logic                       wd12,
  input logic [DW-1:0]              rdata,
  input logic                       eng_rx_put,
  input logic                       irq,
  input logic                       rx_dma_req,
  input logic [$clog2(DEPTH+1)-1:0] rx_cnt,
  input logic [$clog2(DEPTH+1)-1:0] tx_cnt,
  input logic [4:0]                 ie,
  input logic                       st_ov
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] C_IST  = AW'(8);
  localparam logic [AW-1:0] C_FCTL = AW'(12);
  localparam logic [AW-1:0] C_DATA = AW'(16);

  logic data_rd, drop;
  assign data_rd = rd_en && (addr == C_DATA);
  assign drop    = eng_rx_put && (rx_cnt == CW'(DEPTH)) && !data_rd && !(wr_en && (addr == C_FCTL) && wd4);

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rx_cnt) <= DEPTH) && (int'(tx_cnt) <= DEPTH));

  assert_empty_pop_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && (rx_cnt == '0)) |-> (rdata == '0));

  assert_tx_flush_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == C_FCTL) && wd12) |=> (tx_cnt == '0));

  assert_overrun_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> st_ov);

  assert_overrun_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == C_IST) && wd0 && !drop) |=> !st_ov);

  assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ie == 5'd0) |-> !irq);

  assert_rx_dma_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dma_req |-> (rx_cnt != '0));
endmodule

bind spi_fifo_irq spi_fifo_irq_sva #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_sva (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wd0(wdata[0]), .wd4(wdata[4]), .wd12(wdata[12]), .rdata(rdata),
  .eng_rx_put(eng_rx_put), .irq(irq), .rx_dma_req(rx_dma_req),
  .rx_cnt(rx_cnt), .tx_cnt(tx_cnt), .ie(ie), .st_ov(st_ov)
);

// File: tb/test_spi_fifo_irq.sv
module test_spi_fifo_irq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, rd_en = 0, eng_tx_take = 0, eng_rx_put = 0, eng_busy = 0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0, eng_rx_word = '0;
  logic [31:0] rdata, eng_tx_word;
  logic eng_tx_valid, irq, tx_dma_req, rx_dma_req;
  int total = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  spi_fifo_irq i_spi_fifo_irq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .eng_tx_take(eng_tx_take),
    .eng_tx_valid(eng_tx_valid), .eng_tx_word(eng_tx_word),
    .eng_rx_put(eng_rx_put), .eng_rx_word(eng_rx_word), .eng_busy(eng_busy),
    .irq(irq), .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic put(input logic [31:0] d);
    @(negedge clk); eng_rx_put = 1; eng_rx_word = d;
    @(negedge clk); eng_rx_put = 0;
  endtask

  task automatic take();
    @(negedge clk); eng_tx_take = 1;
    @(negedge clk); eng_tx_take = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(6'h00, d); check("R1 status", d, 32'h0);
    rd(6'h04, d); check("R1 enables", d, 32'h0);
    rd(6'h08, d); check("R1 flags", d, 32'h0);
    rd(6'h0C, d); check("R1/R12 thresholds", d, 32'h0701);
    check("R1 outputs", {28'h0, irq, tx_dma_req, rx_dma_req, eng_tx_valid}, 32'h0);
  endtask

  task automatic t_order();
    logic [31:0] d;
    wr(6'h10, 32'hA1); wr(6'h10, 32'hB2); wr(6'h10, 32'hC3);
    check("R2 tx head first", eng_tx_word, 32'hA1);
    take(); check("R2 tx head second", eng_tx_word, 32'hB2);
    take(); check("R2 tx head third", eng_tx_word, 32'hC3);
    put(32'h1111); put(32'h2222);
    rd(6'h00, d); check("R5 not empty", d, 32'h1);
    rd(6'h10, d); check("R2 rx first", d, 32'h1111);
    rd(6'h10, d); check("R2 rx second", d, 32'h2222);
    rd(6'h00, d); check("R5 empty", d, 32'h0);
    eng_busy = 1; tick(1);
    rd(6'h00, d); check("R5 busy", d, 32'h80);
    eng_busy = 0;
    wr(6'h0C, 32'h1711);
  endtask

  task automatic t_full_empty();
    logic [31:0] d;
    wr(6'h08, 32'h19);
    for (int i = 0; i < 9; i++) wr(6'h10, 32'h50 + i);
    for (int i = 0; i < 7; i++) take();
    tick(2);
    rd(6'h08, d); check("R8 not yet drained", d & 32'h10, 32'h0);
    check("R3 last kept word", eng_tx_word, 32'h57);
    take(); tick(2);
    check("R3 ninth write ignored", {31'h0, eng_tx_valid}, 32'h0);
    rd(6'h08, d); check("R8 drained flag", d & 32'h10, 32'h10);
    rd(6'h10, d); check("R3 empty read zero", d, 32'h0);
    rd(6'h00, d); check("R3 empty read no effect", d, 32'h0);
  endtask

  task automatic t_flush();
    logic [31:0] d;
    wr(6'h10, 32'h9); put(32'h7);
    wr(6'h0C, 32'h1711);
    check("R4 tx flushed", {31'h0, eng_tx_valid}, 32'h0);
    rd(6'h00, d); check("R4 rx flushed", d, 32'h0);
    rd(6'h0C, d); check("R12 flush bits read zero", d, 32'h0701);
  endtask

  task automatic t_overrun();
    logic [31:0] d;
    wr(6'h08, 32'h19);
    for (int i = 0; i < 8; i++) put(32'h100 + i);
    tick(2);
    rd(6'h08, d); check("R6 no overrun at full", d & 32'h1, 32'h0);
    put(32'hDEAD); tick(1);
    rd(6'h08, d); check("R6 overrun flag", d & 32'h1, 32'h1);
    for (int i = 0; i < 8; i++) begin
      rd(6'h10, d); check("R6 kept words", d, 32'h100 + i);
    end
    rd(6'h10, d); check("R6 dropped word absent", d, 32'h0);
  endtask

  task automatic t_rx_complete();
    logic [31:0] d;
    wr(6'h0C, 32'h1513);
    wr(6'h08, 32'h19);
    put(32'h1); put(32'h2); tick(2);
    rd(6'h08, d); check("R7 below threshold", d & 32'h208, 32'h0);
    put(32'h3); tick(2);
    rd(6'h08, d); check("R7 at threshold", d & 32'h208, 32'h208);
    rd(6'h10, d); tick(2);
    rd(6'h08, d); check("R7 sticky after drop", d & 32'h208, 32'h008);
    wr(6'h08, 32'h08); tick(1);
    rd(6'h08, d); check("R9 cleared", d & 32'h208, 32'h0);
    wr(6'h0C, 32'h1711);
    put(32'h4); tick(2);
    wr(6'h08, 32'h08); tick(1);
    rd(6'h08, d); check("R9 set wins over clear", d & 32'h8, 32'h8);
    wr(6'h0C, 32'h1711);
  endtask

  task automatic t_irq();
    wr(6'h08, 32'h19); wr(6'h04, 32'h0);
    put(32'h5); tick(2);
    check("R10 masked source", {31'h0, irq}, 32'h0);
    wr(6'h04, 32'h08);
    check("R10 enabled source", {31'h0, irq}, 32'h1);
    wr(6'h0C, 32'h1711); wr(6'h08, 32'h08); tick(1);
    check("R10 cleared", {31'h0, irq}, 32'h0);
    wr(6'h04, 32'h01);
    for (int i = 0; i < 9; i++) put(i);
    tick(1);
    check("R10 overrun irq", {31'h0, irq}, 32'h1);
    wr(6'h08, 32'h01); tick(1);
    check("R10 overrun cleared", {31'h0, irq}, 32'h0);
    wr(6'h0C, 32'h1711); wr(6'h04, 32'h0);
  endtask

  task automatic t_dma();
    wr(6'h04, 32'h06); tick(1);
    check("R11 tx req empty", {30'h0, tx_dma_req, rx_dma_req}, 32'h2);
    for (int i = 0; i < 8; i++) wr(6'h10, i);
    check("R11 tx req full", {31'h0, tx_dma_req}, 32'h0);
    take();
    check("R11 tx req room", {31'h0, tx_dma_req}, 32'h1);
    put(32'h9);
    check("R11 rx req", {31'h0, rx_dma_req}, 32'h1);
    wr(6'h04, 32'h0);
    check("R11 disabled", {30'h0, tx_dma_req, rx_dma_req}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick(1);
    t_reset();
    t_order();
    t_full_empty();
    t_flush();
    t_overrun();
    t_rx_complete();
    t_irq();
    t_dma();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule